// File: doc/BRIEF.md
# Two-Phase Bus Request Decoder

This block sits on the receive side of a system bus. A request reaches it as two 6-bit words on consecutive clocks. The first word comes with the address strobe and the second word follows on the next clock. The block turns the pair into a transaction-type code and a set of attribute fields. It also checks the parity bit that the requester drives with the first word.

All bus inputs are active-low. The block inverts them when it samples them, so every bit value below means "asserted = 1".

It produces three kinds of output:
- a one-cycle valid pulse;
- the type code together with the address size, data size, length, data/code flag and write-snoop flag;
- a one-cycle parity-error pulse.

Any combination that does not match a known transaction still raises the valid pulse, with the reserved type code.

Top module: `bus_req_decoder`

## Requirements
- R1: When the strobe is sampled asserted while idle at edge k, the request bits at edge k form word A and those at edge k+1 form word B. `dec_valid` is high for exactly the one cycle after edge k+1, and outputs change only at that edge.
- R2: A strobe sampled asserted on the word-B clock does not start a new request. Only one valid pulse results.
- R3: Input levels are inverted at capture: a low pin is a 1 bit. A[5:0] and B[5:0] below are asserted values.
- R4: A=000000 with B[5]=0 gives type 1 (deferred reply), with all attributes 0.
- R5: A=001000 with B[5]=0 gives type 2 (interrupt acknowledge) when B[2:0]=000 and type 3 (special) when B[2:0]=001. Data size is B[4:3].
- R6: A=001001 with B[5]=0 gives type 4 (interrupt) when B[2:0]=100 and type 5 (purge TC) when B[2:0]=101. Data size is B[4:3].
- R7: A=010000 gives type 6 (I/O read) and A=010001 gives type 7 (I/O write), whatever B[2:0] is, when B[5]=0. Data size is B[4:3].
- R8: With B[5]=0 the read types are:
  - A[5]=0, A[2:0]=010: type 8 (read and invalidate).
  - A[5]=0, A[2]=1, A[0]=0: type 9 (memory read), with the data/code flag taken from A[1].
  - A[5]=1, A[2:0]=100: type 10 (read current).
  In all three, address size is A[4:3], data size is B[4:3] and length is B[2:0].
- R9: With B[5]=0, A[2]=1 and A[0]=1, the write types are:
  - A[5]=0: type 11 (memory write).
  - A[5]=1 and B[2:0]=000: type 12 (line replacement).
  The write-snoop flag is A[1]. Address size, data size and length are reported as in R8.
- R10: Any other combination, including B[5]=1 and a line replacement with a nonzero length, gives type 0 (reserved). The valid pulse is still raised and all attributes are 0.
- R11: The strobe, the six request bits and the parity bit, all as asserted values, must have an even count of ones. Otherwise `par_err` is high for exactly the one cycle after edge k.
- R12: After reset every output is 0. Type and attributes then hold their value until the next valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_n | input | 1 | Address strobe, active-low |
| req_n | input | 6 | Request word bits, active-low |
| par_n | input | 1 | Request parity bit, active-low |
| dec_valid | output | 1 | One-cycle pulse when a decode is ready |
| dec_type | output | 4 | Transaction type code |
| dec_asz | output | 2 | Address size |
| dec_dsz | output | 2 | Data size |
| dec_len | output | 3 | Length |
| dec_dc | output | 1 | Data/code flag (memory read) |
| dec_wsnp | output | 1 | Write-snoop flag (writes) |
| par_err | output | 1 | One-cycle parity-error pulse |

## Verification
The assertions assume that after reset the inputs only ever carry whole two-clock requests, so each strobe starts a fresh word-A clock. The one exception is the R2 case, where the strobe stays asserted into the word-B clock.

The bench drives every request from a single task. That task applies word A with the strobe on one falling edge and word B on the next. It either releases the strobe or, for R2, holds it exactly one clock longer. It then returns the bus to idle, so no assertion sees overlapping requests.

// File: rtl/breq_pkg.sv
package breq_pkg;
  localparam int REQ_W  = 6;
  localparam int TYPE_W = 4;
  localparam int SZ_W   = 2;
  localparam int LEN_W  = 3;

  typedef enum logic [TYPE_W-1:0] {
    K_RSVD    = 4'd0,
    K_DEFER   = 4'd1,
    K_INTA    = 4'd2,
    K_SPECIAL = 4'd3,
    K_INTR    = 4'd4,
    K_PURGE   = 4'd5,
    K_IO_RD   = 4'd6,
    K_IO_WR   = 4'd7,
    K_MEM_RDI = 4'd8,
    K_MEM_RD  = 4'd9,
    K_MEM_RDC = 4'd10,
    K_MEM_WR  = 4'd11,
    K_LINE_RP = 4'd12
  } req_kind_t;

  typedef struct packed {
    logic [SZ_W-1:0]  asz;
    logic [SZ_W-1:0]  dsz;
    logic [LEN_W-1:0] len;
    logic             dc;
    logic             wsnp;
  } req_attr_t;
endpackage

// File: rtl/breq_capture.sv
module breq_capture
  import breq_pkg::*;
#(
  parameter int W = REQ_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe_n,
  input  logic [W-1:0] req_n,
  input  logic         par_n,
  output logic [W-1:0] word_a,
  output logic [W-1:0] word_b,
  output logic         fire,
  output logic         phase_b,
  output logic         par_err
);
  logic         strobe_hi;
  logic         par_hi;
  logic [W-1:0] req_hi;
  logic         phase_b_d, phase_b_q;
  logic         perr_d, perr_q;
  logic         a_en;
  logic [W-1:0] word_a_q;

  // inversion at the pins: asserted == 1 from here on
  assign strobe_hi = ~strobe_n;
  assign req_hi    = ~req_n;
  assign par_hi    = ~par_n;

  always_comb begin
    phase_b_d = phase_b_q;
    perr_d    = 1'b0;
    a_en      = 1'b0;
    fire      = 1'b0;
    if (phase_b_q) begin
      phase_b_d = 1'b0;
      fire      = 1'b1;
    end else if (strobe_hi) begin
      phase_b_d = 1'b1;
      a_en      = 1'b1;
      perr_d    = ^{strobe_hi, req_hi, par_hi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_b_q <= 1'b0;
      perr_q    <= 1'b0;
      word_a_q  <= '0;
    end else begin
      phase_b_q <= phase_b_d;
      perr_q    <= perr_d;
      if (a_en) word_a_q <= req_hi;
    end
  end

  assign word_a  = word_a_q;
  assign word_b  = req_hi;
  assign phase_b = phase_b_q;
  assign par_err = perr_q;
endmodule

// File: rtl/breq_classify.sv
module breq_classify
  import breq_pkg::*;
(
  input  logic [REQ_W-1:0] a,
  input  logic [REQ_W-1:0] b,
  output req_kind_t        kind,
  output req_attr_t        attr
);
  logic is_mem;

  always_comb begin
    kind   = K_RSVD;
    is_mem = (a[2:1] != 2'b00);
    if (!b[5]) begin
      if (!is_mem) begin
        unique case (a)
          6'b000000: kind = K_DEFER;
          6'b001000: begin
            if (b[2:0] == 3'b000)      kind = K_INTA;
            else if (b[2:0] == 3'b001) kind = K_SPECIAL;
          end
          6'b001001: begin
            if (b[2:0] == 3'b100)      kind = K_INTR;
            else if (b[2:0] == 3'b101) kind = K_PURGE;
          end
          6'b010000: kind = K_IO_RD;
          6'b010001: kind = K_IO_WR;
          default:   kind = K_RSVD;
        endcase
      end else begin
        if (!a[5] && a[2:0] == 3'b010)                  kind = K_MEM_RDI;
        else if (!a[5] && a[2] && !a[0])                kind = K_MEM_RD;
        else if (a[5] && a[2:0] == 3'b100)              kind = K_MEM_RDC;
        else if (!a[5] && a[2] && a[0])                 kind = K_MEM_WR;
        else if (a[5] && a[2] && a[0] && b[2:0] == '0)  kind = K_LINE_RP;
      end
    end
  end

  always_comb begin
    attr = '0;
    if (kind >= K_INTA)    attr.dsz  = b[4:3];
    if (kind >= K_MEM_RDI) begin
      attr.asz = a[4:3];
      attr.len = b[2:0];
    end
    if (kind == K_MEM_RD)  attr.dc   = a[1];
    if (kind == K_MEM_WR || kind == K_LINE_RP) attr.wsnp = a[1];
  end
endmodule

// File: rtl/bus_req_decoder.sv
module bus_req_decoder
  import breq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_n,
  input  logic [REQ_W-1:0] req_n,
  input  logic             par_n,
  output logic             dec_valid,
  output logic [TYPE_W-1:0] dec_type,
  output logic [SZ_W-1:0]  dec_asz,
  output logic [SZ_W-1:0]  dec_dsz,
  output logic [LEN_W-1:0] dec_len,
  output logic             dec_dc,
  output logic             dec_wsnp,
  output logic             par_err
);
  logic [REQ_W-1:0] word_a, word_b;
  logic             fire, phase_b;
  req_kind_t        kind_d;
  req_attr_t        attr_d;
  logic             valid_q;
  req_kind_t        kind_q;
  req_attr_t        attr_q;

  breq_capture #(.W(REQ_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .req_n(req_n),
    .par_n(par_n), .word_a(word_a), .word_b(word_b), .fire(fire),
    .phase_b(phase_b), .par_err(par_err)
  );

  breq_classify u_cls (
    .a(word_a), .b(word_b), .kind(kind_d), .attr(attr_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      kind_q  <= K_RSVD;
      attr_q  <= '0;
    end else begin
      valid_q <= fire;
      if (fire) begin
        kind_q <= kind_d;
        attr_q <= attr_d;
      end
    end
  end

  assign dec_valid = valid_q;
  assign dec_type  = kind_q;
  assign dec_asz   = attr_q.asz;
  assign dec_dsz   = attr_q.dsz;
  assign dec_len   = attr_q.len;
  assign dec_dc    = attr_q.dc;
  assign dec_wsnp  = attr_q.wsnp;
endmodule

// File: rtl/breq_checker.sv
module breq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       strobe_n,
  input logic       phase_b,
  input logic       dec_valid,
  input logic [3:0] dec_type,
  input logic [1:0] dec_asz,
  input logic [1:0] dec_dsz,
  input logic [2:0] dec_len,
  input logic       dec_dc,
  input logic       dec_wsnp,
  input logic       par_err
);
  p_valid_follows_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(phase_b));
  p_b_follows_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase_b |-> $past(!strobe_n) && !$past(phase_b));
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  p_line_rp_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_type == 4'd12) |-> dec_len == 3'd0);
  p_rsvd_attr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_type == 4'd0) |->
      (dec_asz == 2'd0 && dec_dsz == 2'd0 && dec_len == 3'd0 && !dec_dc && !dec_wsnp));
  p_type_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_type <= 4'd12);
  p_perr_after_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> phase_b && !dec_valid);
  p_hold_type_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dec_type) |-> dec_valid);
  p_hold_attr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({dec_asz, dec_dsz, dec_len, dec_dc, dec_wsnp}) |-> dec_valid);
endmodule

bind bus_req_decoder breq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .phase_b(phase_b),
  .dec_valid(dec_valid), .dec_type(dec_type), .dec_asz(dec_asz),
  .dec_dsz(dec_dsz), .dec_len(dec_len), .dec_dc(dec_dc),
  .dec_wsnp(dec_wsnp), .par_err(par_err)
);

// File: tb/bus_req_decoder_bench.sv
module bus_req_decoder_bench;
  logic       clk;
  logic       rst_n;
  logic       strobe_n;
  logic [5:0] req_n;
  logic       par_n;
  logic       dec_valid;
  logic [3:0] dec_type;
  logic [1:0] dec_asz, dec_dsz;
  logic [2:0] dec_len;
  logic       dec_dc, dec_wsnp, par_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bus_req_decoder u_bus_req_decoder (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .req_n(req_n),
    .par_n(par_n), .dec_valid(dec_valid), .dec_type(dec_type),
    .dec_asz(dec_asz), .dec_dsz(dec_dsz), .dec_len(dec_len),
    .dec_dc(dec_dc), .dec_wsnp(dec_wsnp), .par_err(par_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    strobe_n = 1'b1;
    req_n    = 6'h3f;
    par_n    = 1'b1;
  endtask

  // drive a request as asserted values; good parity unless bad_par
  task automatic send(input logic [5:0] a, input logic [5:0] b,
                      input bit bad_par, input bit hold_strobe,
                      output bit perr_seen, output bit valid_seen);
    @(negedge clk);
    strobe_n = 1'b0;
    req_n    = ~a;
    par_n    = ~((^a) ^ 1'b1 ^ bad_par);
    @(negedge clk);
    perr_seen = par_err;
    strobe_n  = hold_strobe ? 1'b0 : 1'b1;
    req_n     = ~b;
    par_n     = 1'b1;
    @(negedge clk);
    valid_seen = dec_valid;
    idle_bus();
  endtask

  task automatic expect_req(input string tag, input logic [5:0] a, input logic [5:0] b,
                            input int t, input int asz, input int dsz, input int len,
                            input int dc, input int wsnp);
    bit pe, vs;
    send(a, b, 1'b0, 1'b0, pe, vs);
    chk(vs == 1'b1, {tag, " valid"}, vs, 1);
    chk(dec_type == t[3:0], {tag, " type"}, dec_type, t);
    chk(dec_asz == asz[1:0] && dec_dsz == dsz[1:0] && dec_len == len[2:0]
        && dec_dc == dc[0] && dec_wsnp == wsnp[0], {tag, " attrs"},
        {dec_asz, dec_dsz, dec_len, dec_dc, dec_wsnp},
        {asz[1:0], dsz[1:0], len[2:0], dc[0], wsnp[0]});
    chk(pe == 1'b0, {tag, " no parity error"}, pe, 0);
    @(negedge clk);
    chk(dec_valid == 1'b0, {tag, " R1 pulse width"}, dec_valid, 0);
  endtask

  task automatic t_reset();
    chk(dec_valid == 0 && dec_type == 0 && par_err == 0, "R12 reset outputs",
        {dec_valid, dec_type, par_err}, 0);
    chk({dec_asz, dec_dsz, dec_len, dec_dc, dec_wsnp} == 0, "R12 reset attrs",
        {dec_asz, dec_dsz, dec_len, dec_dc, dec_wsnp}, 0);
  endtask

  task automatic t_nonmem();
    expect_req("R4 defer", 6'b000000, 6'b011111, 1, 0, 0, 0, 0, 0);
    expect_req("R5 inta", 6'b001000, 6'b010000, 2, 0, 2, 0, 0, 0);
    expect_req("R5 special", 6'b001000, 6'b001001, 3, 0, 1, 0, 0, 0);
    expect_req("R6 intr", 6'b001001, 6'b011100, 4, 0, 3, 0, 0, 0);
    expect_req("R6 purge", 6'b001001, 6'b000101, 5, 0, 0, 0, 0, 0);
    expect_req("R7 io read", 6'b010000, 6'b001111, 6, 0, 1, 0, 0, 0);
    expect_req("R7 io write", 6'b010001, 6'b010010, 7, 0, 2, 0, 0, 0);
  endtask

  task automatic t_mem();
    expect_req("R8 rd inval", 6'b010010, 6'b011011, 8, 2, 3, 3, 0, 0);
    expect_req("R8 rd code", 6'b001110, 6'b000101, 9, 1, 0, 5, 1, 0);
    expect_req("R8 rd data", 6'b011100, 6'b001000, 9, 3, 1, 0, 0, 0);
    expect_req("R8 rd current", 6'b110100, 6'b010111, 10, 2, 2, 7, 0, 0);
    expect_req("R9 mem write", 6'b001111, 6'b011110, 11, 1, 3, 6, 0, 1);
    expect_req("R9 line repl", 6'b111101, 6'b001000, 12, 3, 1, 0, 0, 0);
  endtask

  task automatic t_reserved();
    expect_req("R10 defer b5", 6'b000000, 6'b100000, 0, 0, 0, 0, 0, 0);
    expect_req("R10 a 000001", 6'b000001, 6'b000000, 0, 0, 0, 0, 0, 0);
    expect_req("R10 inta b010", 6'b001000, 6'b000010, 0, 0, 0, 0, 0, 0);
    expect_req("R10 intr b110", 6'b001001, 6'b000110, 0, 0, 0, 0, 0, 0);
    expect_req("R10 a 000011", 6'b000011, 6'b011111, 0, 0, 0, 0, 0, 0);
    expect_req("R10 a 100110", 6'b100110, 6'b000001, 0, 0, 0, 0, 0, 0);
    expect_req("R10 line repl len", 6'b111101, 6'b001010, 0, 0, 0, 0, 0, 0);
    expect_req("R10 memwr b5", 6'b001111, 6'b111110, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_parity();
    bit pe, vs;
    send(6'b001110, 6'b000101, 1'b1, 1'b0, pe, vs);
    chk(pe == 1'b1, "R11 bad parity flagged", pe, 1);
    chk(vs == 1'b1 && dec_type == 4'd9, "R11 decode still valid", dec_type, 9);
    chk(par_err == 1'b0, "R11 error pulse one cycle", par_err, 0);
    send(6'b010001, 6'b000000, 1'b0, 1'b0, pe, vs);
    chk(pe == 1'b0, "R11 good parity quiet", pe, 0);
    chk(dec_type == 4'd7, "R3 inverted capture io write", dec_type, 7);
  endtask

  task automatic t_hold_strobe();
    bit pe, vs;
    int pulses = 0;
    send(6'b010000, 6'b001000, 1'b0, 1'b1, pe, vs);
    if (vs) pulses++;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (dec_valid) pulses++;
    end
    chk(pulses == 1, "R2 strobe on word B ignored", pulses, 1);
    chk(dec_type == 4'd6 && dec_dsz == 2'd1, "R2 decode kept", dec_type, 6);
  endtask

  task automatic t_hold();
    expect_req("R12 setup", 6'b011100, 6'b011011, 9, 3, 3, 3, 0, 0);
    req_n = 6'b000000;
    repeat (5) @(negedge clk);
    chk(dec_valid == 0 && dec_type == 4'd9 && dec_len == 3'd3 && dec_asz == 2'd3,
        "R12 outputs hold while idle", dec_type, 9);
    idle_bus();
  endtask

  initial begin
    #200000;
    chk(done, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle_bus();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nonmem();
    t_mem();
    t_reserved();
    t_parity();
    t_hold_strobe();
    t_hold();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule